// File: doc/BRIEF.md
# Half-Rate to Full-Rate Phase-Enabled Data Transfer

This block carries a data word from a slow clock domain into a fast clock domain that a clock multiplier derives from it at exactly twice the frequency. The two clocks are related in frequency, but the skew between their edges is not tightly controlled. Because of that skew, capturing slow-domain data on the nominally aligned fast edge is unsafe, and an asynchronous FIFO would cost far more storage than the problem needs.

The slow clock enters the block as an ordinary signal. A flop on the falling edge of the fast clock samples it, and a rising-edge flop then brings that sample into the fast domain. Watching that copy for low-to-high changes rebuilds the slow clock's phase inside the fast domain. A one-cycle enable derived from it captures the slow word on a fast edge that sits well clear of the edge where the slow data switches. Each capture raises a one-cycle valid strobe. The output word then holds until the next capture.

After reset, the block ignores a set number of detected slow-clock rises before it trusts its phase copy. This keeps a clock or reset that starts part-way through a period from causing a bad first capture.

Top module: `p2x_phase_xfer`

## Requirements
- R1: On each falling edge of `clk2x_i`, the block samples `slow_clk_i`. A slow-clock rise counts as detected when one falling-edge sample reads 1 and the sample before it reads 0. After reset, the block treats the sample before the first falling edge as 0.
- R2: For an enabled rise first sampled high on falling edge N, `valid_o` is high as seen at falling edge N+3. That is, `valid_o` goes high on the third rising edge of `clk2x_i` after falling edge N.
- R3: `valid_o` is high for exactly one `clk2x_i` cycle per detected slow-clock rise. It is never high in two consecutive cycles.
- R4: In the cycle in which `valid_o` is high, `data_o` equals the word present on `data_1x_i` at that capture edge. Whenever `valid_o` is low, `data_o` keeps its previous value.
- R5: After reset, the first `ARM_EDGES` detected rises (default 2) produce no capture. Every later rise produces exactly one capture.
- R6: While `rst_ni` is low, `data_o` is 0 and `valid_o` is 0. Arming restarts after every reset.
- R7: If `slow_clk_i` stops toggling, `valid_o` stays low once the captures already in flight have drained, and `data_o` holds.
- R8: The slow-clock rise may land anywhere inside a fast cycle, including after the falling edge of `clk2x_i`. In that case it is detected one falling edge later, and the behaviour of R2 to R4 is unchanged.
- R9: The data width is the parameter `WIDTH`, default 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk2x_i | input | 1 | Fast clock, twice the slow clock frequency |
| rst_ni | input | 1 | Active-low asynchronous reset |
| slow_clk_i | input | 1 | Slow clock, treated as a data signal |
| data_1x_i | input | WIDTH | Word launched in the slow domain |
| data_o | output | WIDTH | Captured word in the fast domain |
| valid_o | output | 1 | One-cycle strobe on each capture |

## Verification
The bench builds the block with its defaults: `WIDTH` of 16 and `ARM_EDGES` of 2. With two arming rises, the skip of the first captures after reset is short enough to check both at start-up and after a reset applied mid-run. The 16-bit words are distinct enough that a capture from the wrong slow period shows up at once.

The bench sweeps the slow clock's lead over the fast edge through several values before the falling edge, and one value after it. This exercises both the direct detection path and the one-cycle-late detection path. It also checks that the strobe drains to zero when the slow clock stops.

// File: rtl/p2x_pkg.sv
`timescale 1ns/1ps
package p2x_pkg;
  // counter width able to hold 0..n, never below 1
  function automatic int cnt_w(input int n);
    int w;
    w = $clog2(n + 1);
    return (w < 1) ? 1 : w;
  endfunction
endpackage

// File: rtl/p2x_phase_sense.sv
`timescale 1ns/1ps
module p2x_phase_sense (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slow_clk_i,
  output logic rise_o
);
  logic s_neg_q, s_q, s_prev_q;

  // sample slow clock mid fast cycle, away from either clock's rising edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s_neg_q <= 1'b0;
    else         s_neg_q <= slow_clk_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_q      <= 1'b0;
      s_prev_q <= 1'b0;
    end else begin
      s_q      <= s_neg_q;
      s_prev_q <= s_q;
    end
  end

  assign rise_o = s_q & ~s_prev_q;
endmodule

// File: rtl/p2x_arm_gate.sv
`timescale 1ns/1ps
module p2x_arm_gate #(
  parameter int ARM_EDGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  output logic en_o,
  output logic armed_o
);
  localparam int CW = p2x_pkg::cnt_w(ARM_EDGES);
  localparam logic [CW-1:0] ARM_LIM = CW'(ARM_EDGES);

  logic [CW-1:0] cnt_q;
  logic          en_q;

  assign armed_o = (cnt_q == ARM_LIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else begin
      en_q <= rise_i & armed_o;
      if (rise_i && !armed_o) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign en_o = en_q;
endmodule

// File: rtl/p2x_capture.sv
`timescale 1ns/1ps
module p2x_capture #(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o,
  output logic             vld_o
);
  logic [WIDTH-1:0] q_q;
  logic             vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q   <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= en_i;
      if (en_i) q_q <= d_i;
    end
  end

  assign q_o   = q_q;
  assign vld_o = vld_q;
endmodule

// File: rtl/p2x_phase_xfer.sv
`timescale 1ns/1ps
module p2x_phase_xfer #(
  parameter int WIDTH     = 16,
  parameter int ARM_EDGES = 2
) (
  input  logic             clk2x_i,
  input  logic             rst_ni,
  input  logic             slow_clk_i,
  input  logic [WIDTH-1:0] data_1x_i,
  output logic [WIDTH-1:0] data_o,
  output logic             valid_o
);
  logic rise_w, en_w, armed_w;

  p2x_phase_sense u_sense (
    .clk_i      (clk2x_i),
    .rst_ni     (rst_ni),
    .slow_clk_i (slow_clk_i),
    .rise_o     (rise_w)
  );

  p2x_arm_gate #(.ARM_EDGES(ARM_EDGES)) u_gate (
    .clk_i   (clk2x_i),
    .rst_ni  (rst_ni),
    .rise_i  (rise_w),
    .en_o    (en_w),
    .armed_o (armed_w)
  );

  p2x_capture #(.WIDTH(WIDTH)) u_cap (
    .clk_i  (clk2x_i),
    .rst_ni (rst_ni),
    .en_i   (en_w),
    .d_i    (data_1x_i),
    .q_o    (data_o),
    .vld_o  (valid_o)
  );
endmodule

// File: rtl/p2x_phase_xfer_chk.sv
`timescale 1ns/1ps
module p2x_phase_xfer_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rise_i,
  input logic             en_i,
  input logic             armed_i,
  input logic             valid_i,
  input logic [WIDTH-1:0] data_i
);
  p_en_after_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> $past(rise_i));

  p_en_to_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> valid_i);

  p_valid_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> !valid_i);

  p_data_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> $stable(data_i));

  p_valid_armed_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> armed_i);
endmodule

bind p2x_phase_xfer p2x_phase_xfer_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i   (clk2x_i),
  .rst_ni  (rst_ni),
  .rise_i  (rise_w),
  .en_i    (en_w),
  .armed_i (armed_w),
  .valid_i (valid_o),
  .data_i  (data_o)
);

// File: tb/tb_p2x_phase_xfer.sv
`timescale 1ns/1ps
module tb_p2x_phase_xfer;
  localparam int W   = 16;
  localparam int ARM = 2;
  localparam int NT  = 12;
  // {skew[4:0], word[15:0]}; skew = slow-clock delay after fast rising edge, ns
  localparam logic [20:0] TBL [NT] = '{
    {5'd1, 16'hA5A5}, {5'd1, 16'h5A5A}, {5'd3, 16'h1234}, {5'd3, 16'hFEDC},
    {5'd5, 16'h0001}, {5'd5, 16'h8000}, {5'd8, 16'hFFFF}, {5'd8, 16'h0000},
    {5'd2, 16'hC3C3}, {5'd6, 16'h3C3C}, {5'd4, 16'h7E81}, {5'd7, 16'h9669}};

  logic         clk = 1'b0, rst_n = 1'b0, slow = 1'b0;
  logic [W-1:0] data_in = '0;
  logic [W-1:0] data_o;
  logic         valid_o;

  int n_chk = 0, n_fail = 0, n_pulse = 0;
  bit done = 0;

  p2x_phase_xfer #(.WIDTH(W), .ARM_EDGES(ARM)) dut (
    .clk2x_i(clk), .rst_ni(rst_n), .slow_clk_i(slow),
    .data_1x_i(data_in), .data_o(data_o), .valid_o(valid_o));

  initial forever #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h @%0t", req, act, exp, $time);
    end
  endtask

  // reference model, evaluated at every falling edge
  logic [2:0]   ev = '0;
  logic         prev_s = 1'b0;
  logic [W-1:0] last_d = '0;
  int           seen = 0;
  initial forever begin
    @(negedge clk);
    if (!rst_n) begin
      chk(valid_o == 1'b0, "R6 valid in reset", 32'(valid_o), 0);
      chk(data_o == '0, "R6 data in reset", 32'(data_o), 0);
      ev = '0; prev_s = 1'b0; last_d = '0; seen = 0;
    end else begin
      logic r;
      chk(valid_o == ev[2], "R2/R3/R5 valid timing", 32'(valid_o), 32'(ev[2]));
      if (valid_o) begin
        n_pulse++;
        chk(data_o == data_in, "R4 captured word", 32'(data_o), 32'(data_in));
      end else begin
        chk(data_o == last_d, "R4 hold", 32'(data_o), 32'(last_d));
      end
      r = slow & ~prev_s;  // R1 rise seen on falling-edge samples
      ev = {ev[1:0], r && (seen >= ARM)};
      if (r && seen < ARM) seen++;
      prev_s = slow;
      last_d = data_o;
    end
  end

  task automatic one_period(input logic [W-1:0] w, input int sk);
    @(posedge clk); #sk slow = 1'b1; #1 data_in = w;
    @(posedge clk); #sk slow = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    int p0;
    idle(3);
    @(negedge clk); #1 rst_n = 1'b1;

    // table walk across skews before the falling edge
    p0 = n_pulse;
    for (int i = 0; i < NT; i++) one_period(TBL[i][15:0], int'(TBL[i][20:16]));
    idle(6);
    chk(n_pulse - p0 == NT - ARM, "R5 arming skips first rises", 32'(n_pulse - p0), 32'(NT - ARM));

    // R7 slow clock stops
    p0 = n_pulse;
    data_in = 16'hDEAD;
    idle(20);
    chk(n_pulse == p0, "R7 no strobe when slow clock idle", 32'(n_pulse - p0), 0);
    chk(data_o == 16'h7E81 || data_o == 16'h9669, "R7 output holds", 32'(data_o), 32'h9669);

    // R8 skew past the falling edge
    p0 = n_pulse;
    one_period(16'h0F0F, 14); one_period(16'hF0F0, 14);
    one_period(16'h6666, 14); one_period(16'h9999, 14);
    idle(6);
    chk(n_pulse - p0 == 4, "R8 late skew captures", 32'(n_pulse - p0), 4);
    chk(data_o == 16'h9999, "R8 last word", 32'(data_o), 32'h9999);

    // R6 reset mid-run then re-arm
    @(negedge clk); #1 rst_n = 1'b0;
    idle(3);
    @(negedge clk); #1 rst_n = 1'b1;
    p0 = n_pulse;
    one_period(16'h1111, 3); one_period(16'h2222, 3); one_period(16'h3333, 3);
    idle(6);
    chk(n_pulse - p0 == 1, "R6 re-arm after reset", 32'(n_pulse - p0), 1);
    chk(data_o == 16'h3333, "R9 full width word", 32'(data_o), 32'h3333);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=1 exp=0");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule